// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Compare

This block is the decision core of an eight-line interrupt controller. It takes three values: a vector of qualified requests (already masked by whatever holds the mask), a vector of lines currently in service, and a rotation base. Priority is relative to the base. Level 0 is the most urgent, and level p belongs to line (p + base) mod N. The block finds the most urgent pending request. It asserts its interrupt output only when that request strictly outranks everything in service.

A second scan over the full in-service vector reports the most urgent line in service. The surrounding controller needs this line to retire an interrupt with a non-specific end-of-interrupt. The block also reports the rotation base that would make that line the least urgent. A special nested mode lets a cascade line re-enter while it is already in service. This mode applies only to an instance built as the primary controller. All outputs are combinational and settle within one clock cycle.

Top module: `prr_resolver`

## Requirements
- R1: With no line in service, the interrupt is given to the request at the lowest priority level. Level p corresponds to line (p + rot_base) mod 8.
- R2: When req_vec is all zero, irq_valid is 0 and irq_line is 0.
- R3: irq_valid is 1 only when the request's level is strictly smaller than the level of the most urgent in-service line. An equal or larger level gives irq_valid 0 and irq_line 0.
- R4: isr_valid is 1 exactly when isr_vec is non-zero. isr_line is the in-service line at the lowest level under the same rotation, and it is 0 when isr_valid is 0.
- R5: With nest_mode 1 on a primary instance, in-service bit 2 (the cascade line) is left out of the compare in R3. The other in-service bits still take part.
- R6: nest_mode has no effect on isr_valid, isr_line or eoi_base.
- R7: eoi_base is (isr_line + 1) mod 8 when isr_valid is 1, so that line becomes least urgent. It equals rot_base when isr_valid is 0.
- R8: Every output follows its inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Qualified pending requests, one bit per line |
| isr_vec | input | 8 | Lines currently in service |
| rot_base | input | 3 | Line that holds priority level 0 |
| nest_mode | input | 1 | Special nested mode: ignore the cascade line in the compare |
| irq_valid | output | 1 | A request outranks everything in service |
| irq_line | output | 3 | Winning request line, 0 when irq_valid is 0 |
| isr_valid | output | 1 | At least one line is in service |
| isr_line | output | 3 | Most urgent in-service line, 0 when none |
| eoi_base | output | 3 | Rotation base that makes isr_line least urgent |

## Verification
The hardest case to reach is the boundary where the request and the most urgent in-service line sit at the same level. That happens either because both are the same line, or because the rotation wraps the in-service line to level 7 while the request is also at level 7. The stimulus table drives both on purpose: a line 0 request while line 0 is in service with base 1, and a request and an in-service line on either side of the wrap point. The cascade exclusion is reached by setting nest_mode with bit 2 in service alone, and again with bit 2 next to a more urgent in-service bit that must still block.

// File: rtl/prr_pkg.sv
package prr_pkg;
    // Default geometry of one controller instance.
    localparam int PRR_LINES     = 8;
    localparam int PRR_CASC_LINE = 2;
endpackage

// File: rtl/prr_scan.sv
// Finds the lowest rotated priority level that has its bit set.
// The result is N when the vector is empty.
module prr_scan #(
    parameter  int N  = prr_pkg::PRR_LINES,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] base,
    output logic [LW:0]   level
);
    logic [N-1:0] rot;

    // rot[p] is the bit of the line that sits at level p.
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [LW-1:0] src;
        assign src    = base + LW'(g);
        assign rot[g] = vec[src];
    end

    always_comb begin
        level = (LW+1)'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (rot[p]) level = (LW+1)'(p);
        end
    end

    // A found level must point at a set bit of the input.
    always_comb begin
        if (!level[LW]) begin
            p_level_hits_set_bit_r1: assert (vec[base + level[LW-1:0]])
                else $error("scan level points at a clear bit");
        end
    end
endmodule

// File: rtl/prr_compare.sv
// Strict-less compare of two rotated levels; the value N means none.
module prr_compare #(
    parameter  int N  = prr_pkg::PRR_LINES,
    localparam int LW = $clog2(N)
) (
    input  logic [LW:0] req_level,
    input  logic [LW:0] cur_level,
    output logic        outranks
);
    assign outranks = (req_level < cur_level);

    always_comb begin
        if (req_level[LW]) begin
            p_empty_never_outranks_r2: assert (!outranks)
                else $error("empty request outranked in-service set");
        end
    end
endmodule

// File: rtl/prr_resolver.sv
module prr_resolver #(
    parameter  int N          = prr_pkg::PRR_LINES,
    parameter  int CASC_LINE  = prr_pkg::PRR_CASC_LINE,
    parameter  bit IS_PRIMARY = 1'b1,
    localparam int LW         = $clog2(N)
) (
    input  logic [N-1:0]  req_vec,
    input  logic [N-1:0]  isr_vec,
    input  logic [LW-1:0] rot_base,
    input  logic          nest_mode,
    output logic          irq_valid,
    output logic [LW-1:0] irq_line,
    output logic          isr_valid,
    output logic [LW-1:0] isr_line,
    output logic [LW-1:0] eoi_base
);
    localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_LINE;

    initial begin
        p_geometry_pow2_r1: assert ((1 << LW) == N && CASC_LINE < N)
            else $error("line count must be a power of two");
    end

    logic [N-1:0] isr_cmp;
    logic [LW:0]  req_lvl;
    logic [LW:0]  cmp_lvl;
    logic [LW:0]  top_lvl;
    logic         take;

    // R5: the cascade line drops out of the compare in nested mode.
    assign isr_cmp = isr_vec & ~({N{nest_mode & IS_PRIMARY}} & CASC_BIT);

    prr_scan #(.N(N)) u_req_scan (.vec(req_vec), .base(rot_base), .level(req_lvl));
    prr_scan #(.N(N)) u_cmp_scan (.vec(isr_cmp), .base(rot_base), .level(cmp_lvl));
    prr_scan #(.N(N)) u_isr_scan (.vec(isr_vec), .base(rot_base), .level(top_lvl));

    prr_compare #(.N(N)) u_cmp (.req_level(req_lvl), .cur_level(cmp_lvl), .outranks(take));

    always_comb begin
        irq_valid = take;
        irq_line  = take ? (rot_base + req_lvl[LW-1:0]) : '0;
        isr_valid = !top_lvl[LW];
        isr_line  = isr_valid ? (rot_base + top_lvl[LW-1:0]) : '0;
        eoi_base  = isr_valid ? (isr_line + LW'(1)) : rot_base;
    end

    always_comb begin
        if (irq_valid) begin
            p_winner_is_requested_r1: assert (req_vec[irq_line])
                else $error("winning line is not requested");
            p_winner_not_in_service_r3: assert (!isr_cmp[irq_line])
                else $error("winning line is already in service");
        end else begin
            p_idle_line_zero_r2: assert (irq_line == '0)
                else $error("irq_line not zero while idle");
        end
        if (req_vec == '0) begin
            p_no_request_no_irq_r2: assert (!irq_valid)
                else $error("interrupt without any request");
        end
        if (isr_valid) begin
            p_top_isr_is_set_r4: assert (isr_vec[isr_line])
                else $error("reported in-service line is clear");
        end else begin
            p_eoi_keeps_base_r7: assert (eoi_base == rot_base)
                else $error("base moved with nothing in service");
        end
    end
endmodule

// File: tb/sim_prr_resolver.sv
module sim_prr_resolver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_vec = '0;
    logic [7:0] isr_vec = '0;
    logic [2:0] rot_base = '0;
    logic       nest_mode = 1'b0;
    logic       irq_valid, isr_valid;
    logic [2:0] irq_line, isr_line, eoi_base;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prr_resolver u0 (
        .req_vec(req_vec), .isr_vec(isr_vec), .rot_base(rot_base),
        .nest_mode(nest_mode), .irq_valid(irq_valid), .irq_line(irq_line),
        .isr_valid(isr_valid), .isr_line(isr_line), .eoi_base(eoi_base)
    );

    // Row: {req, isr, base, nest, expected valid, expected line}
    localparam logic [23:0] ROWS [17] = '{
        {8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0},  // R2 empty
        {8'h01, 8'h00, 3'd0, 1'b0, 1'b1, 3'd0},  // R1
        {8'h84, 8'h00, 3'd0, 1'b0, 1'b1, 3'd2},  // R1
        {8'h84, 8'h00, 3'd3, 1'b0, 1'b1, 3'd7},  // R1 rotated
        {8'h84, 8'h00, 3'd7, 1'b0, 1'b1, 3'd7},  // R1
        {8'h10, 8'h04, 3'd0, 1'b0, 1'b0, 3'd0},  // R3 lower
        {8'h04, 8'h04, 3'd0, 1'b0, 1'b0, 3'd0},  // R3 equal
        {8'h02, 8'h04, 3'd0, 1'b0, 1'b1, 3'd1},  // R3 higher
        {8'h10, 8'h04, 3'd0, 1'b1, 1'b1, 3'd4},  // R5 cascade ignored
        {8'h04, 8'h04, 3'd0, 1'b1, 1'b1, 3'd2},  // R5 re-entry
        {8'h10, 8'h0C, 3'd0, 1'b1, 1'b0, 3'd0},  // R5 other bit blocks
        {8'h01, 8'h01, 3'd1, 1'b0, 1'b0, 3'd0},  // R3 equal at level 7
        {8'h01, 8'h80, 3'd1, 1'b0, 1'b0, 3'd0},  // R3 wrap, lower
        {8'h01, 8'h80, 3'd0, 1'b0, 1'b1, 3'd0},  // R3 wrap, higher
        {8'hFF, 8'h00, 3'd5, 1'b0, 1'b1, 3'd5},  // R1 all requests
        {8'hFF, 8'h20, 3'd5, 1'b0, 1'b0, 3'd0},  // R3 level 0 in service
        {8'hFF, 8'h40, 3'd5, 1'b0, 1'b1, 3'd5}   // R3
    };

    // Independent model: {found, line} of the first set bit in rotated order.
    function automatic logic [3:0] ref_pick(input logic [7:0] v, input logic [2:0] b);
        for (int p = 0; p < 8; p++) begin
            if (v[(p + b) % 8]) return {1'b1, 3'((p + b) % 8)};
        end
        return 4'b0000;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] r, input logic [7:0] s,
                         input logic [2:0] b, input logic n);
        @(posedge clk);
        #2;
        req_vec = r; isr_vec = s; rot_base = b; nest_mode = n;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero inputs give all-zero outputs (R2, R4, R7)
        check("R2 reset irq_valid", irq_valid, 0);
        check("R2 reset irq_line", irq_line, 0);
        check("R4 reset isr_valid", isr_valid, 0);
        check("R7 reset eoi_base", eoi_base, 0);
        rst = 1'b0;

        for (int i = 0; i < 17; i++) begin
            logic [3:0] hp;
            drive(ROWS[i][23:16], ROWS[i][15:8], ROWS[i][7:5], ROWS[i][4]);
            check($sformatf("R1/R2/R3/R5 row %0d irq_valid", i), irq_valid, ROWS[i][3]);
            check($sformatf("R1/R2/R3/R5 row %0d irq_line", i), irq_line, ROWS[i][2:0]);
            hp = ref_pick(ROWS[i][15:8], ROWS[i][7:5]);
            check($sformatf("R4 row %0d isr_valid", i), isr_valid, hp[3]);
            check($sformatf("R4 row %0d isr_line", i), isr_line, hp[2:0]);
            check($sformatf("R7 row %0d eoi_base", i), eoi_base,
                  hp[3] ? int'(3'(hp[2:0] + 3'd1)) : int'(ROWS[i][7:5]));
        end

        // R4 / R7: lines 4 and 7 in service, base 5 -> line 7 wins, base wraps to 0
        drive(8'h00, 8'h90, 3'd5, 1'b0);
        check("R4 rotated isr_line", isr_line, 7);
        check("R7 wrap eoi_base", eoi_base, 0);

        // R7: nothing in service keeps the base
        drive(8'h00, 8'h00, 3'd6, 1'b0);
        check("R7 idle eoi_base", eoi_base, 6);
        check("R4 idle isr_line", isr_line, 0);

        // R6: nested mode leaves the in-service helper untouched
        drive(8'h00, 8'h04, 3'd0, 1'b1);
        check("R6 nest isr_valid", isr_valid, 1);
        check("R6 nest isr_line", isr_line, 2);
        check("R6 nest eoi_base", eoi_base, 3);

        // R8: change inputs mid-phase, no clock edge, outputs follow
        req_vec = 8'h08; isr_vec = 8'h00; rot_base = 3'd0; nest_mode = 1'b0;
        #1;
        check("R8 comb irq_valid", irq_valid, 1);
        check("R8 comb irq_line", irq_line, 3);
        req_vec = 8'h00;
        #1;
        check("R8 comb drop", irq_valid, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule